// File: doc/BRIEF.md
# Dual Wiper Register Controller

This block holds the digital state of a two-channel stepped potentiometer. Each channel has an 8-bit wiper register whose value picks one tap out of 256 through a one-hot tap-select bus. Each channel also has four 8-bit storage registers. These model nonvolatile cells: they have no reset, so their contents survive the power-up reset. When reset is released, each wiper reloads itself from storage slot 0 of its own channel.

A serial front end decodes the commands and presents them one per cycle while chip select is low. The commands are:
- read a wiper register or a storage slot;
- write a wiper register;
- copy a storage slot into its wiper;
- copy a wiper into a storage slot;
- write a storage slot;
- step a wiper up or down by one tap.

Wiper changes take effect at once. A storage write is only armed when its command arrives. It commits after chip select rises, at the end of a timed busy period. A low write-protect input blocks and cancels storage writes but never blocks wiper changes.

Top module: `dual_wiper_ctrl`

## Requirements
- R1: Each tap-select output has exactly one bit set, at the index equal to its wiper value.
- R2: Storage slots keep their contents through `rst_n`. In the first clock cycle after `rst_n` goes high, each wiper loads its own slot 0, and commands in that cycle are ignored.
- R3: Command code 1 (write wiper) loads `cmdData` into the wiper chosen by `cmdWiper` at the next clock edge, whatever the level of `wpN`.
- R4: Command code 0 (read wiper) and command code 2 (read slot `cmdReg` of wiper `cmdWiper`) put the value on `rdData`, with `rdValid` high, one cycle after the command.
- R5: Command code 6 adds one to the chosen wiper and command code 7 subtracts one. The value saturates at 255 and at 0 and never wraps.
- R6: Command code 5 copies slot `cmdReg` of the chosen wiper into that wiper.
- R7: Command code 3 (write `cmdData` to a slot) and command code 4 (copy the wiper into a slot) only arm a storage write; the slot keeps its old value while chip select stays low. On the first clock after `csN` rises with a write armed, `busy` goes high for WRITE_CYCLES cycles (default 8). The slot takes the new value as `busy` falls.
- R8: A storage write command issued while `wpN` is low is ignored: `busy` does not assert and the slot is unchanged.
- R9: If `wpN` is low in any cycle while `csN` is low after a storage write is armed, the write is cancelled. The later rise of `csN` then gives no busy period and no change to the slot.
- R10: Once the busy period has started, `wpN` going low neither shortens it nor stops the commit.
- R11: A storage write command issued while `busy` is high is ignored, and no second busy period follows it.
- R12: Commands presented while `csN` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset (storage slots not reset) |
| csN | input | 1 | Active-low chip select from the serial front end |
| wpN | input | 1 | Active-low write protect for storage slots |
| cmdValid | input | 1 | One-cycle command strobe |
| cmdOp | input | 3 | Command code (0..7, see requirements) |
| cmdWiper | input | 1 | Wiper channel select |
| cmdReg | input | 2 | Storage slot index |
| cmdData | input | 8 | Data for write commands |
| rdData | output | 8 | Read result |
| rdValid | output | 1 | Read result valid |
| busy | output | 1 | Storage commit in progress |
| tapSel0 | output | 256 | One-hot tap select, channel 0 |
| tapSel1 | output | 256 | One-hot tap select, channel 1 |

## Verification
The bench targets these corner cases:
- **Commit timing.** It reads a slot back while chip select is still low, after an armed write. A design that committed at once would return the new value too early. The bench also counts the busy cycles, so a miscounted busy period shows up.
- **Write-protect cases.** It lowers write-protect before a write, during the pending window and during the busy period. This separates cancellation from a commit that has already started, and it catches a write-protect that wrongly gates wiper writes.
- **Saturation and recall.** It steps wipers past 255 and below 0 to catch wraparound. It pulses reset after loading all slots, which catches slots that get cleared or a recall taken from the wrong slot.
- **Ignored commands.** It sends commands during busy and with chip select high, each of which must leave every value untouched.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
  localparam int NUM_WIPERS = 2;
  localparam int SLOTS = 4;
  localparam int IDX_W = $clog2(SLOTS);

  typedef enum logic [2:0] {
    OP_RD_WIPER = 3'd0,
    OP_WR_WIPER = 3'd1,
    OP_RD_SLOT  = 3'd2,
    OP_WR_SLOT  = 3'd3,
    OP_SAVE     = 3'd4,
    OP_LOAD     = 3'd5,
    OP_STEP_UP  = 3'd6,
    OP_STEP_DN  = 3'd7
  } op_e;

  typedef struct packed {
    logic             recall;
    logic             wrWiper;
    logic             ldWiper;
    logic             incr;
    logic             decr;
    logic             rdWiper;
    logic             rdSlot;
    logic             armStore;
    logic             armFromWiper;
    logic             commit;
    logic             sel;
    logic [IDX_W-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/dwc_ctrl.sv
module dwc_ctrl
  import dwc_pkg::*;
#(
  parameter int WRITE_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csN,
  input  logic             wpN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic             cmdWiper,
  input  logic [IDX_W-1:0] cmdReg,
  output strobe_t          strobe,
  output logic             busy
);
  localparam int CNT_W = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;

  logic             recallQ;
  logic             csPrevQ;
  logic             pendQ;
  logic             busyQ;
  logic [CNT_W-1:0] cntQ;

  op_e  op;
  logic accept;
  logic storeOp;
  logic csRise;
  logic commitStart;
  logic busyDone;

  always_comb begin
    op          = op_e'(cmdOp);
    accept      = cmdValid && !csN && !recallQ;
    storeOp     = (op == OP_WR_SLOT) || (op == OP_SAVE);
    csRise      = csN && !csPrevQ;
    commitStart = csRise && pendQ;
    busyDone    = busyQ && (cntQ == '0);

    strobe              = '0;
    strobe.recall       = recallQ;
    strobe.wrWiper      = accept && (op == OP_WR_WIPER);
    strobe.ldWiper      = accept && (op == OP_LOAD);
    strobe.incr         = accept && (op == OP_STEP_UP);
    strobe.decr         = accept && (op == OP_STEP_DN);
    strobe.rdWiper      = accept && (op == OP_RD_WIPER);
    strobe.rdSlot       = accept && (op == OP_RD_SLOT);
    strobe.armStore     = accept && storeOp && wpN && !busyQ;
    strobe.armFromWiper = (op == OP_SAVE);
    strobe.commit       = busyDone;
    strobe.sel          = cmdWiper;
    strobe.idx          = cmdReg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      recallQ <= 1'b1;
      csPrevQ <= 1'b1;
      pendQ   <= 1'b0;
      busyQ   <= 1'b0;
      cntQ    <= '0;
    end else begin
      recallQ <= 1'b0;
      csPrevQ <= csN;
      if (strobe.armStore) pendQ <= 1'b1;
      else if (!csN && !wpN) pendQ <= 1'b0;
      else if (csRise) pendQ <= 1'b0;
      if (commitStart) begin
        busyQ <= 1'b1;
        cntQ  <= CNT_W'(WRITE_CYCLES - 1);
      end else if (busyQ) begin
        if (cntQ == '0) busyQ <= 1'b0;
        else cntQ <= cntQ - 1'b1;
      end
    end
  end

  assign busy = busyQ;

  // R7: busy starts only on the clock right after chip select rose
  assert_commit_after_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busyQ) |-> ($past(csN) && !$past(csN, 2)));

  // R9: write-protect low while selected leaves nothing to commit on the next edge
  assert_wp_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!csN && !wpN && !busyQ) |=> !$rose(busyQ));
endmodule

// File: rtl/dwc_datapath.sv
module dwc_datapath
  import dwc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  strobe_t                            strobe,
  input  logic [DATA_W-1:0]                  cmdData,
  output logic [NUM_WIPERS-1:0][DATA_W-1:0]  wiperVal,
  output logic [DATA_W-1:0]                  rdData,
  output logic                               rdValid
);
  localparam logic [DATA_W-1:0] MAXV = '1;

  logic [NUM_WIPERS-1:0][DATA_W-1:0]            wiperQ;
  logic [NUM_WIPERS-1:0][SLOTS-1:0][DATA_W-1:0] slotQ;
  logic [DATA_W-1:0] pendDataQ;
  logic              pendSelQ;
  logic [IDX_W-1:0]  pendIdxQ;
  logic [DATA_W-1:0] rdDataQ;
  logic              rdValidQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiperQ   <= '0;
      rdDataQ  <= '0;
      rdValidQ <= 1'b0;
    end else begin
      rdValidQ <= strobe.rdWiper | strobe.rdSlot;
      if (strobe.rdWiper) rdDataQ <= wiperQ[strobe.sel];
      else if (strobe.rdSlot) rdDataQ <= slotQ[strobe.sel][strobe.idx];
      for (int w = 0; w < NUM_WIPERS; w++) begin
        if (strobe.recall) begin
          wiperQ[w] <= slotQ[w][0];
        end else if (int'(strobe.sel) == w) begin
          if (strobe.wrWiper) wiperQ[w] <= cmdData;
          else if (strobe.ldWiper) wiperQ[w] <= slotQ[w][strobe.idx];
          else if (strobe.incr && (wiperQ[w] != MAXV)) wiperQ[w] <= wiperQ[w] + 1'b1;
          else if (strobe.decr && (wiperQ[w] != '0)) wiperQ[w] <= wiperQ[w] - 1'b1;
        end
      end
    end
  end

  // Storage model: no reset, contents survive the power-up reset
  always_ff @(posedge clk) begin
    if (strobe.armStore) begin
      pendDataQ <= strobe.armFromWiper ? wiperQ[strobe.sel] : cmdData;
      pendSelQ  <= strobe.sel;
      pendIdxQ  <= strobe.idx;
    end
    if (strobe.commit) slotQ[pendSelQ][pendIdxQ] <= pendDataQ;
  end

  assign wiperVal = wiperQ;
  assign rdData   = rdDataQ;
  assign rdValid  = rdValidQ;

  // R7: slots only move on a commit strobe from control
  assert_slot_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.commit |=> $stable(slotQ));

  // R5: stepping up at full scale stays at full scale
  assert_sat_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.incr && !strobe.recall && (wiperQ[strobe.sel] == MAXV))
      |=> (wiperQ[$past(strobe.sel)] == MAXV));

  // R3: a wiper write lands on the next edge
  assert_wr_wiper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrWiper && !strobe.recall) |=> (wiperQ[$past(strobe.sel)] == $past(cmdData)));
endmodule

// File: rtl/dwc_tap_decode.sv
module dwc_tap_decode #(
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DATA_W-1:0]      value,
  output logic [(1<<DATA_W)-1:0] tap
);
  localparam int TAPS = 1 << DATA_W;

  assign tap = {{(TAPS-1){1'b0}}, 1'b1} << value;

  // R1: exactly one tap closed at a time
  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap) == 1);
endmodule

// File: rtl/dual_wiper_ctrl.sv
module dual_wiper_ctrl
  import dwc_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   csN,
  input  logic                   wpN,
  input  logic                   cmdValid,
  input  logic [2:0]             cmdOp,
  input  logic                   cmdWiper,
  input  logic [IDX_W-1:0]       cmdReg,
  input  logic [DATA_W-1:0]      cmdData,
  output logic [DATA_W-1:0]      rdData,
  output logic                   rdValid,
  output logic                   busy,
  output logic [(1<<DATA_W)-1:0] tapSel0,
  output logic [(1<<DATA_W)-1:0] tapSel1
);
  localparam int TAPS = 1 << DATA_W;

  strobe_t                           strobe;
  logic [NUM_WIPERS-1:0][DATA_W-1:0] wiperVal;
  logic [NUM_WIPERS-1:0][TAPS-1:0]   tapArr;

  dwc_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .csN(csN), .wpN(wpN),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdWiper(cmdWiper), .cmdReg(cmdReg),
    .strobe(strobe), .busy(busy)
  );

  dwc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cmdData(cmdData),
    .wiperVal(wiperVal), .rdData(rdData), .rdValid(rdValid)
  );

  for (genvar i = 0; i < NUM_WIPERS; i++) begin : g_tap
    dwc_tap_decode #(.DATA_W(DATA_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .value(wiperVal[i]), .tap(tapArr[i])
    );
  end

  assign tapSel0 = tapArr[0];
  assign tapSel1 = tapArr[1];
endmodule

// File: tb/tb_dual_wiper_ctrl.sv
`timescale 1ns/1ps
module tb_dual_wiper_ctrl;
  localparam int WC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csN = 1'b1;
  logic wpN = 1'b1;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = '0;
  logic cmdWiper = 1'b0;
  logic [1:0] cmdReg = '0;
  logic [7:0] cmdData = '0;
  logic [7:0] rdData;
  logic rdValid;
  logic busy;
  logic [255:0] tapSel0;
  logic [255:0] tapSel1;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] expW [2];
  logic [7:0] expS [2][4];

  always #2.5 clk = ~clk;

  dual_wiper_ctrl dut (
    .clk(clk), .rst_n(rst_n), .csN(csN), .wpN(wpN), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdWiper(cmdWiper), .cmdReg(cmdReg), .cmdData(cmdData),
    .rdData(rdData), .rdValid(rdValid), .busy(busy),
    .tapSel0(tapSel0), .tapSel1(tapSel1)
  );

  function automatic logic [7:0] stepUp(logic [7:0] v);
    return (v == 8'hFF) ? v : v + 8'd1;
  endfunction
  function automatic logic [7:0] stepDn(logic [7:0] v);
    return (v == 8'h00) ? v : v - 8'd1;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkTaps(string tag);
    checks++;
    if (tapSel0 !== (256'b1 << expW[0]) || tapSel1 !== (256'b1 << expW[1])) begin
      failures++;
      $display("FAIL %s taps actual=%0h/%0h expected index=%0h/%0h",
               tag, tapSel0, tapSel1, expW[0], expW[1]);
    end
  endtask

  task automatic doCmd(int op, int w, int r, logic [7:0] d);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'(op); cmdWiper = w[0]; cmdReg = 2'(r); cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic readWiper(int w, string tag);
    doCmd(0, w, 0, 8'h00);
    check({tag, " rdValid"}, rdValid, 1);
    check({tag, " wiper read"}, rdData, expW[w]);
  endtask

  task automatic readSlot(int w, int r, string tag);
    doCmd(2, w, r, 8'h00);
    check({tag, " rdValid"}, rdValid, 1);
    check({tag, " slot read"}, rdData, expS[w][r]);
  endtask

  // raise chip select, count busy cycles, lower chip select again
  task automatic csCycle(int expBusy, bit dropWp, string tag);
    int n = 0;
    @(negedge clk);
    csN = 1'b1;
    for (int i = 0; i < WC + 6; i++) begin
      @(negedge clk);
      if (busy) n++;
      if (dropWp && i == 2) wpN = 1'b0;
    end
    wpN = 1'b1;
    check({tag, " busy cycles"}, n, expBusy);
    @(negedge clk);
    csN = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // reset state
    check("R1 tap0 onehot after reset", $countones(tapSel0), 1);
    check("R1 tap1 onehot after reset", $countones(tapSel1), 1);
    check("R7 busy low after reset", busy, 0);
    check("R4 rdValid low after reset", rdValid, 0);

    csN = 1'b0;
    // fill every slot (R7)
    for (int w = 0; w < 2; w++) begin
      for (int r = 0; r < 4; r++) begin
        logic [7:0] v = 8'(8'h11 * (w * 4 + r) + 8'h05);
        doCmd(3, w, r, v);
        csCycle(WC, 0, "R7 fill");
        expS[w][r] = v;
      end
    end
    for (int w = 0; w < 2; w++)
      for (int r = 0; r < 4; r++) readSlot(w, r, "R7 fill readback");

    // recall on reset (R2)
    @(negedge clk); rst_n = 1'b0; csN = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    expW[0] = expS[0][0]; expW[1] = expS[1][0];
    checkTaps("R2 recall slot0");
    csN = 1'b0;
    readSlot(0, 3, "R2 slot kept");
    readSlot(1, 2, "R2 slot kept");
    readWiper(1, "R4 read wiper1");

    // write protect does not gate wiper writes (R3), blocks storage (R8)
    @(negedge clk); wpN = 1'b0;
    doCmd(1, 0, 0, 8'hA5); expW[0] = 8'hA5;
    checkTaps("R3 wiper write under wp");
    doCmd(3, 0, 1, 8'h77);
    @(negedge clk); wpN = 1'b1;
    csCycle(0, 0, "R8 protected write");
    readSlot(0, 1, "R8 slot unchanged");

    // cancel while pending (R9)
    doCmd(3, 1, 1, 8'h99);
    readSlot(1, 1, "R7 no commit before cs rise");
    @(negedge clk); wpN = 1'b0;
    @(negedge clk); wpN = 1'b1;
    csCycle(0, 0, "R9 cancelled write");
    readSlot(1, 1, "R9 slot unchanged");

    // wp during busy does not stop it (R10)
    doCmd(3, 1, 3, 8'h42);
    csCycle(WC, 1, "R10 wp during busy");
    expS[1][3] = 8'h42;
    readSlot(1, 3, "R10 commit done");

    // storage command while busy ignored (R11)
    begin
      int n = 0;
      doCmd(3, 0, 2, 8'h5A);
      @(negedge clk); csN = 1'b1;
      @(negedge clk); if (busy) n++;
      @(negedge clk); if (busy) n++; csN = 1'b0;
      @(negedge clk); if (busy) n++;
      cmdValid = 1'b1; cmdOp = 3'd3; cmdWiper = 1'b0; cmdReg = 2'd0; cmdData = 8'hE7;
      @(negedge clk); if (busy) n++; cmdValid = 1'b0; csN = 1'b1;
      for (int i = 0; i < WC + 8; i++) begin
        @(negedge clk); if (busy) n++;
      end
      check("R11 single busy period", n, WC);
      csN = 1'b0;
      expS[0][2] = 8'h5A;
      readSlot(0, 2, "R11 first write kept");
      readSlot(0, 0, "R11 busy write ignored");
    end

    // save wiper into slot (R7) and load slot into wiper (R6)
    doCmd(1, 1, 0, 8'h3C); expW[1] = 8'h3C;
    doCmd(4, 1, 2, 8'h00);
    doCmd(1, 1, 0, 8'h01); expW[1] = 8'h01;
    csCycle(WC, 0, "R7 save");
    expS[1][2] = 8'h3C;
    readSlot(1, 2, "R7 save captured value");
    doCmd(5, 0, 3, 8'h00); expW[0] = expS[0][3];
    checkTaps("R6 load slot");

    // saturation (R5)
    doCmd(1, 0, 0, 8'hFE); expW[0] = 8'hFE;
    doCmd(6, 0, 0, 8'h00); expW[0] = 8'hFF;
    doCmd(6, 0, 0, 8'h00);
    checkTaps("R5 saturate high");
    doCmd(7, 1, 0, 8'h00); expW[1] = 8'h00;
    doCmd(7, 1, 0, 8'h00);
    checkTaps("R5 saturate low");
    readWiper(0, "R5 read high");

    // deselected commands ignored (R12)
    @(negedge clk); csN = 1'b1;
    doCmd(1, 0, 0, 8'h12);
    doCmd(6, 1, 0, 8'h00);
    @(negedge clk);
    checkTaps("R12 ignored while deselected");
    check("R12 no busy", busy, 0);
    csN = 1'b0;

    // constrained random wiper traffic
    for (int it = 0; it < 300; it++) begin
      int sel = $urandom_range(5);
      int w = $urandom_range(1);
      int r = $urandom_range(3);
      logic [7:0] d = 8'($urandom);
      int op;
      case (sel)
        0: op = 0; 1: op = 1; 2: op = 2; 3: op = 5; 4: op = 6; default: op = 7;
      endcase
      if (op == 1 && d[0]) d = d[7] ? 8'hFF : 8'h00;
      if (op == 0) readWiper(w, "R4 random");
      else if (op == 2) readSlot(w, r, "R4 random");
      else begin
        doCmd(op, w, r, d);
        case (op)
          1: expW[w] = d;
          5: expW[w] = expS[w][r];
          6: expW[w] = stepUp(expW[w]);
          default: expW[w] = stepDn(expW[w]);
        endcase
        checkTaps("R1 random");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule